// File: doc/BRIEF.md
# Split or Joined Interval Timer Pair

Two interval timers, channel A and channel B, share one register port. In split operation each channel is a 16-bit counter with an 8-bit prescaler, and each runs on its own in one-shot or periodic mode, counting up or down. A single configuration bit joins the two 16-bit counters into one 32-bit counter. In that case channel A's mode word drives the joined timer, and channel B's load and match registers supply the upper halves of the 32-bit limit and compare values.

The 8-bit prescaler does a different job in each direction. When a split channel counts down, the prescaler is a true predivider: it runs from its reload value down to zero before the 16-bit count moves by one. When a split channel counts up, the prescaler holds bits 23:16 of a plain 24-bit count. Each channel raises a one-cycle timeout pulse and a one-cycle match pulse. Software writes registers through a single-cycle write strobe and reads them through a combinational read address.

Register addresses (the word at address N): 0 join control (bit 0 = 1 joins the counters); 1/2 mode word of A/B (bit 0 enable, bit 1 periodic when 1 and one-shot when 0, bit 2 count up when 1); 3/4 load of A/B; 5/6 match of A/B; 7/8 prescale reload of A/B; 9/10 prescale match of A/B; 11/12 count value of A/B. Unused addresses read zero.

Top module: `gp_timer_pair`

## Requirements
- R1: After reset every register reads zero and all four event outputs are low.
- R2: A write to a value address (11 or 12) sets that channel's count at the write's clock edge. The write takes priority over counting. In split operation the value reads back as {8'h00, prescaler, count16}.
- R3: A split channel counting down with load L and prescale reload P steps its prescaler from P to 0 before each decrement of the count. It signals timeout while both are zero. In periodic mode it then reloads {P, L}, which gives a period of (L+1)*(P+1) cycles.
- R4: A split channel counting up increments {prescaler, count16} as one 24-bit value. It signals timeout while that value equals {prescale reload, load}, and in periodic mode it restarts from zero.
- R5: A split channel pulses match in each cycle that it is enabled and {prescaler, count16} equals {prescale match, match}.
- R6: At a one-shot timeout the enable bit (bit 0 of the mode word) clears by itself and the count holds its value.
- R7: A channel whose enable bit is clear keeps its count unchanged and raises no events.
- R8: With the counters joined, the 32-bit count is {B count, A count}, with a borrow or carry passing across bit 15. Limit and match are {B reg, A reg}. Channel A's mode word governs, channel B's mode word is ignored, B's outputs stay low, and address 11 reads and writes all 32 bits.
- R9: A joined timer counting up in periodic mode signals timeout when the count equals the 32-bit limit and then restarts from zero.
- R10: In split operation the two channels run independently, and activity on one does not change the other's count or events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| a_timeout | output | 1 | Channel A (or joined timer) timeout pulse |
| a_match | output | 1 | Channel A (or joined timer) match pulse |
| b_timeout | output | 1 | Channel B timeout pulse |
| b_match | output | 1 | Channel B match pulse |

## Verification
The hardest cases to reach are the joined counter crossing bit 15 and the prescaler wrapping. A free run would need tens of thousands of cycles to get there. The bench therefore writes the count directly to a value just short of the boundary (0x00010001 counting down, 0x0000FFFF counting up, 0x0FFFF in split up-count). It then watches the next few cycles, so the carry or borrow and the timeout show up inside a short window. The down-count predivider is tested with a tiny load and prescale, so that several full periods and their match positions fit in a 32-cycle trace.

// File: rtl/gp_timer_pair.sv
module gp_timer_pair #(
  parameter int HALF_W = 16,
  parameter int PSC_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [2*HALF_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [2*HALF_W-1:0]   rd_data,
  output logic                  a_timeout,
  output logic                  a_match,
  output logic                  b_timeout,
  output logic                  b_match
);
  localparam int FULL_W = 2*HALF_W;
  localparam int EXT_W  = HALF_W + PSC_W;
  localparam int M_EN = 0, M_PER = 1, M_UP = 2;
  localparam logic [ADDR_W-1:0] AD_JOIN = 0, AD_MODE = 1, AD_LOAD = 3, AD_MAT = 5,
                                AD_PSC = 7, AD_PMAT = 9, AD_VAL = 11;

  logic              concat;
  logic [2:0]        mode   [2];
  logic [HALF_W-1:0] load_r [2];
  logic [HALF_W-1:0] mat_r  [2];
  logic [HALF_W-1:0] cnt    [2];
  logic [PSC_W-1:0]  psc_r  [2];
  logic [PSC_W-1:0]  pmat_r [2];
  logic [PSC_W-1:0]  pre    [2];
  logic [EXT_W-1:0]  ext    [2];
  logic [1:0]        en, term, hit;
  logic [FULL_W-1:0] wide, load_w, mat_w;

  assign wide   = {cnt[1], cnt[0]};
  assign load_w = {load_r[1], load_r[0]};
  assign mat_w  = {mat_r[1], mat_r[0]};

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      ext[i] = {pre[i], cnt[i]};
      if (concat) begin
        en[i]   = (i == 0) && mode[0][M_EN];
        term[i] = mode[0][M_UP] ? (wide == load_w) : (wide == '0);
        hit[i]  = (wide == mat_w);
      end else begin
        en[i]   = mode[i][M_EN];
        term[i] = mode[i][M_UP] ? (ext[i] == {psc_r[i], load_r[i]}) : (ext[i] == '0);
        hit[i]  = (ext[i] == {pmat_r[i], mat_r[i]});
      end
    end
  end

  assign a_timeout = en[0] & term[0];
  assign a_match   = en[0] & hit[0];
  assign b_timeout = en[1] & term[1];
  assign b_match   = en[1] & hit[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      concat <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        mode[i] <= '0; load_r[i] <= '0; mat_r[i] <= '0; cnt[i] <= '0;
        psc_r[i] <= '0; pmat_r[i] <= '0; pre[i] <= '0;
      end
    end else begin
      if (concat) begin
        if (en[0]) begin
          if (term[0]) begin
            if (mode[0][M_PER]) {cnt[1], cnt[0]} <= mode[0][M_UP] ? '0 : load_w;
            else mode[0][M_EN] <= 1'b0;
          end else begin
            {cnt[1], cnt[0]} <= mode[0][M_UP] ? wide + 1'b1 : wide - 1'b1;
          end
        end
      end else begin
        for (int i = 0; i < 2; i++) begin
          if (en[i]) begin
            if (term[i]) begin
              if (!mode[i][M_PER]) mode[i][M_EN] <= 1'b0;
              else if (mode[i][M_UP]) {pre[i], cnt[i]} <= '0;
              else begin
                pre[i] <= psc_r[i];
                cnt[i] <= load_r[i];
              end
            end else if (mode[i][M_UP]) begin
              {pre[i], cnt[i]} <= ext[i] + 1'b1;
            end else if (pre[i] != '0) begin
              pre[i] <= pre[i] - 1'b1;
            end else begin
              pre[i] <= psc_r[i];
              cnt[i] <= cnt[i] - 1'b1;
            end
          end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          AD_JOIN:     concat    <= wr_data[0];
          AD_MODE:     mode[0]   <= wr_data[2:0];
          AD_MODE+1:   mode[1]   <= wr_data[2:0];
          AD_LOAD:     load_r[0] <= wr_data[HALF_W-1:0];
          AD_LOAD+1:   load_r[1] <= wr_data[HALF_W-1:0];
          AD_MAT:      mat_r[0]  <= wr_data[HALF_W-1:0];
          AD_MAT+1:    mat_r[1]  <= wr_data[HALF_W-1:0];
          AD_PSC:      psc_r[0]  <= wr_data[PSC_W-1:0];
          AD_PSC+1:    psc_r[1]  <= wr_data[PSC_W-1:0];
          AD_PMAT:     pmat_r[0] <= wr_data[PSC_W-1:0];
          AD_PMAT+1:   pmat_r[1] <= wr_data[PSC_W-1:0];
          AD_VAL: begin
            if (concat) {cnt[1], cnt[0]} <= wr_data;
            else {pre[0], cnt[0]} <= wr_data[EXT_W-1:0];
          end
          AD_VAL+1: if (!concat) {pre[1], cnt[1]} <= wr_data[EXT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      AD_JOIN:   rd_data = FULL_W'(concat);
      AD_MODE:   rd_data = FULL_W'(mode[0]);
      AD_MODE+1: rd_data = FULL_W'(mode[1]);
      AD_LOAD:   rd_data = FULL_W'(load_r[0]);
      AD_LOAD+1: rd_data = FULL_W'(load_r[1]);
      AD_MAT:    rd_data = FULL_W'(mat_r[0]);
      AD_MAT+1:  rd_data = FULL_W'(mat_r[1]);
      AD_PSC:    rd_data = FULL_W'(psc_r[0]);
      AD_PSC+1:  rd_data = FULL_W'(psc_r[1]);
      AD_PMAT:   rd_data = FULL_W'(pmat_r[0]);
      AD_PMAT+1: rd_data = FULL_W'(pmat_r[1]);
      AD_VAL:    rd_data = concat ? wide : FULL_W'(ext[0]);
      AD_VAL+1:  rd_data = concat ? FULL_W'(cnt[1]) : FULL_W'(ext[1]);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gp_timer_pair_chk.sv
module gp_timer_pair_chk #(
  parameter int HALF_W = 16,
  parameter int PSC_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [2*HALF_W-1:0]       wr_data,
  input logic                      concat,
  input logic [2:0]                mode_a,
  input logic [HALF_W-1:0]         load_a,
  input logic [PSC_W-1:0]          psc_a,
  input logic [HALF_W-1:0]         cnt_a,
  input logic [PSC_W-1:0]          pre_a,
  input logic                      a_timeout,
  input logic                      b_timeout,
  input logic                      b_match
);
  localparam logic [ADDR_W-1:0] AD_VAL = 11;

  a_r2_value_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AD_VAL && !concat) |=> ({pre_a, cnt_a} == $past(wr_data[HALF_W+PSC_W-1:0])));

  a_r3_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (a_timeout && !concat && mode_a[1] && !mode_a[2] && !wr_en) |=> (cnt_a == load_a && pre_a == psc_a));

  a_r6_one_shot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (a_timeout && !mode_a[1] && !wr_en) |=> !mode_a[0]);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_a[0] && !wr_en) |=> ($stable(cnt_a) && $stable(pre_a)));

  a_r8_b_quiet_joined: assert property (@(posedge clk) disable iff (!rst_n)
    concat |-> (!b_timeout && !b_match));
endmodule

bind gp_timer_pair gp_timer_pair_chk #(.HALF_W(HALF_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .concat(concat), .mode_a(mode[0]), .load_a(load_r[0]), .psc_a(psc_r[0]),
  .cnt_a(cnt[0]), .pre_a(pre[0]), .a_timeout(a_timeout),
  .b_timeout(b_timeout), .b_match(b_match));

// File: tb/sim_gp_timer_pair.sv
module sim_gp_timer_pair;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        a_timeout, a_match, b_timeout, b_match;
  int checks = 0, errors = 0;
  logic [31:0] ta, ma, tb, mb;
  logic [31:0] rv [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_timer_pair u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .a_timeout(a_timeout),
    .a_match(a_match), .b_timeout(b_timeout), .b_match(b_match));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic watch(input logic [3:0] a);
    rd_addr = a;
    ta = '0; ma = '0; tb = '0; mb = '0;
    for (int k = 0; k < 32; k++) begin
      #1;
      ta[k] = a_timeout; ma[k] = a_match; tb[k] = b_timeout; mb[k] = b_match;
      rv[k] = rd_data;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], d);
      chk("R1 register reads zero", d, 32'h0);
    end
    chk("R1 events low", {28'h0, a_timeout, a_match, b_timeout, b_match}, 32'h0);
  endtask

  task automatic t_split_down();
    do_reset();
    wr(7, 1); wr(3, 3); wr(5, 2); wr(9, 0);
    wr(11, 32'h0001_0003);
    wr(1, 32'b011);
    watch(11);
    chk("R2 split value readback", rv[0], 32'h0001_0003);
    chk("R2 predivider stepped", rv[1], 32'h0000_0003);
    chk("R3 down timeout cycles", ta, 32'h8080_8080);
    chk("R5 match cycles", ma, 32'h0808_0808);
    chk("R10 B idle", tb | mb, 32'h0);
  endtask

  task automatic t_one_shot_idle();
    logic [31:0] d0, d1;
    do_reset();
    wr(3, 2); wr(11, 2); wr(1, 32'b001);
    watch(11);
    chk("R6 single timeout", ta, 32'h0000_0004);
    chk("R6 count holds", rv[31], 32'h0);
    rd(1, d0);
    chk("R6 enable cleared", d0, 32'h0);
    wr(11, 32'h0000_0009);
    rd(11, d0);
    repeat (6) @(negedge clk);
    rd(11, d1);
    chk("R7 disabled count unchanged", d1, d0);
    chk("R7 disabled no events", {31'h0, a_timeout | a_match}, 32'h0);
  endtask

  task automatic t_split_up();
    logic [31:0] exp;
    do_reset();
    wr(3, 4); wr(11, 0); wr(1, 32'b111);
    watch(11);
    exp = '0;
    for (int k = 4; k < 32; k += 5) exp[k] = 1'b1;
    chk("R4 up timeout cycles", ta, exp);
    chk("R4 restart from zero", rv[5], 32'h0);
    wr(1, 0); wr(7, 2); wr(11, 32'h0000_FFFF); wr(1, 32'b101);
    watch(11);
    chk("R4 prescaler as upper bits", rv[1], 32'h0001_0000);
    chk("R4 no early timeout", ta, 32'h0);
  endtask

  task automatic t_independent();
    do_reset();
    wr(11, 32'h55);
    wr(4, 1); wr(12, 1); wr(2, 32'b011);
    watch(11);
    chk("R10 B periodic timeouts", tb, 32'hAAAA_AAAA);
    chk("R10 A untouched", rv[31], 32'h55);
    chk("R10 A quiet", ta | ma, 32'h0);
  endtask

  task automatic t_joined();
    logic [31:0] d;
    do_reset();
    wr(0, 1);
    wr(3, 2); wr(4, 1); wr(5, 32'hFFFF); wr(6, 0);
    wr(11, 32'h0001_0001);
    rd(12, d);
    chk("R8 B value reads upper half", d, 32'h1);
    wr(2, 32'b111);
    wr(1, 32'b001);
    watch(11);
    chk("R8 borrow across halves", rv[1], 32'h0001_0000);
    chk("R8 32-bit match", ma, 32'h0000_0004);
    chk("R8 B outputs low", tb | mb, 32'h0);
    wr(11, 2);
    watch(11);
    chk("R8 joined one-shot timeout", ta, 32'h0000_0004);
    rd(1, d);
    chk("R8 A enable cleared", d, 32'h0);
    chk("R8 B mode ignored", tb | mb, 32'h0);
  endtask

  task automatic t_joined_up();
    do_reset();
    wr(0, 1);
    wr(3, 1); wr(4, 1); wr(11, 32'h0000_FFFF); wr(1, 32'b111);
    watch(11);
    chk("R9 carry across halves", rv[1], 32'h0001_0000);
    chk("R9 timeout at limit", ta[3:0], 32'h4);
    chk("R9 restart from zero", rv[3], 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_split_down();
    t_one_shot_idle();
    t_split_up();
    t_independent();
    t_joined();
    t_joined_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule